// File: doc/BRIEF.md
# Reset and Power-Down Controller

This block decides when the core of a small microcontroller is held in reset and when its oscillator is stopped. A reset starts in three ways: the power-on pulse, a low level on the already synchronized external reset pin, or a watchdog expiry while the watchdog is enabled. Once a reset starts, the core stays in reset for a start-up interval. That interval is counted in start-up ticks and is set by the `HOLD_TICKS` parameter. A new reset that arrives during the interval starts the count again.

The block keeps two status flags. Software reads them after a reset to find out what caused it:

- T, the time-out flag;
- P, the power-down flag.

A sleep instruction stops the oscillator, and the only way out of sleep is a full reset. The block also asks for the watchdog to be cleared when needed. It drives the constant values that the control registers load while the core is in reset.

Top module: `rstpd_ctrl`

## Requirements
- R1: While `por_i` is high, with no clock edge needed, `core_rst_o`=1, `osc_stop_o`=0, `tflag_o`=1, `pflag_o`=1 and `wdt_clr_o`=1.
- R2: A reset event is a cycle with `rst_pin_n_i`=0, or with `wdt_expire_i`=1 and `wdt_en_i`=1. An expiry while `wdt_en_i`=0 changes no output.
- R3: After the last reset event, `core_rst_o` stays 1 until `HOLD_TICKS` cycles with `tick_i`=1 have been sampled. It goes to 0 just after the edge that samples the last of them. A tick in a cycle that also holds a reset event is not counted.
- R4: A reset event during the hold restarts the tick count from zero.
- R5: An accepted `sleep_i` strobe gives `osc_stop_o`=1, `tflag_o`=1 and `pflag_o`=0 after the next edge.
- R6: An accepted `wdtc_i` strobe gives `tflag_o`=1 and `pflag_o`=1 after the next edge.
- R7: A reset event caused by an enabled watchdog expiry clears `tflag_o` and leaves `pflag_o` as it was. A reset event caused by the pin leaves both flags as they were.
- R8: Once asleep, `osc_stop_o` stays 1 until a reset event, which clears it and raises `core_rst_o`. A strobe is accepted only when all of the following hold in that cycle:
  - `core_rst_o`=0;
  - `osc_stop_o`=0;
  - there is no reset event.

  Any other strobe is ignored.
- R9: `wdt_clr_o` is 1 whenever `core_rst_o` is 1. It is also 1 for the one cycle that follows an accepted sleep or watchdog-clear strobe.
- R10: The register defaults are constants:
  - `init_tmrctl_o` is all ones;
  - `init_wden_o` is 1;
  - `init_ropt_o` is 0;
  - `init_stat_top_o` is all zeros;
  - `init_port_dir_o` is all ones, where 1 means input.
- R11: When `sleep_i` and `wdtc_i` are accepted in the same cycle, sleep wins: `osc_stop_o`=1, `tflag_o`=1, `pflag_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| rst_pin_n_i | input | 1 | Synchronized external reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog expiry |
| wdt_en_i | input | 1 | Watchdog enable qualifying the expiry |
| sleep_i | input | 1 | Sleep instruction strobe |
| wdtc_i | input | 1 | Watchdog-clear instruction strobe |
| tick_i | input | 1 | Start-up interval tick |
| core_rst_o | output | 1 | Core held in reset |
| osc_stop_o | output | 1 | Oscillator stop request (sleep) |
| tflag_o | output | 1 | Time-out flag value |
| pflag_o | output | 1 | Power-down flag value |
| wdt_clr_o | output | 1 | Clear watchdog and prescaler |
| init_tmrctl_o | output | CTL_W | Reset value of the timer control field |
| init_stat_top_o | output | STAT_TOP_W | Reset value of the upper status bits |
| init_port_dir_o | output | PORT_W | Reset value of the port directions |
| init_wden_o | output | 1 | Reset value of the watchdog enable bit |
| init_ropt_o | output | 1 | Reset value of the resistor-option enable bit |

## Verification
The bench builds the block with `HOLD_TICKS`=3 and the default widths (`CTL_W`=6, `STAT_TOP_W`=3, `PORT_W`=12). With a terminal count of three, the following are each reached in a handful of ticks:

- the release edge;
- a restart part-way through the hold;
- a tick that is discarded because it coincides with a reset event.

These short intervals leave room to walk through every cause-flag pattern: power-on, watchdog expiry awake and asleep, pin wake, and a sleep/clear collision.

// File: rtl/rstpd_pkg.sv
package rstpd_pkg;

   typedef enum logic {
      PWR_RUN   = 1'b0,
      PWR_SLEEP = 1'b1
   } pwr_state_e;

   typedef struct packed {
      logic tflag;
      logic pflag;
   } cause_flags_t;

   localparam cause_flags_t FLAGS_POR = '{tflag: 1'b1, pflag: 1'b1};

endpackage

// File: rtl/rstpd_event.sv
module rstpd_event (
   input  logic rst_pin_n_i,
   input  logic wdt_expire_i,
   input  logic wdt_en_i,
   output logic ev_o,
   output logic wdt_ev_o
);
   logic pin_ev;

   always_comb begin
      pin_ev   = ~rst_pin_n_i;
      wdt_ev_o = wdt_expire_i & wdt_en_i;
      ev_o     = pin_ev | wdt_ev_o;
   end
endmodule

// File: rtl/rstpd_hold.sv
module rstpd_hold #(
   parameter int HOLD_TICKS = 8
) (
   input  logic clk,
   input  logic por_i,
   input  logic ev_i,
   input  logic tick_i,
   output logic hold_o
);
   logic hold_q;

   generate
      if (HOLD_TICKS == 1) begin : g_single
         always_ff @(posedge clk or posedge por_i) begin
            if (por_i)       hold_q <= 1'b1;
            else if (ev_i)   hold_q <= 1'b1;
            else if (tick_i) hold_q <= 1'b0;
         end
      end else begin : g_count
         localparam int CNT_W = $clog2(HOLD_TICKS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or posedge por_i) begin
            if (por_i) begin
               hold_q <= 1'b1;
               cnt_q  <= '0;
            end else if (ev_i) begin
               hold_q <= 1'b1;
               cnt_q  <= '0;
            end else if (hold_q && tick_i) begin
               if (cnt_q == LAST) begin
                  hold_q <= 1'b0;
                  cnt_q  <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign hold_o = hold_q;
endmodule

// File: rtl/rstpd_power.sv
module rstpd_power
   import rstpd_pkg::*;
(
   input  logic clk,
   input  logic por_i,
   input  logic ev_i,
   input  logic wdt_ev_i,
   input  logic hold_i,
   input  logic sleep_i,
   input  logic wdtc_i,
   output logic asleep_o,
   output logic tflag_o,
   output logic pflag_o,
   output logic clr_pulse_o
);
   pwr_state_e   pwr_q;
   cause_flags_t flags_q;
   logic         pulse_q;
   logic         accept;

   assign accept = ~ev_i & ~hold_i & (pwr_q == PWR_RUN);

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         pwr_q   <= PWR_RUN;
         flags_q <= FLAGS_POR;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (ev_i) begin
            pwr_q <= PWR_RUN;
            if (wdt_ev_i) flags_q.tflag <= 1'b0;
         end else if (accept && sleep_i) begin
            pwr_q   <= PWR_SLEEP;
            flags_q <= '{tflag: 1'b1, pflag: 1'b0};
            pulse_q <= 1'b1;
         end else if (accept && wdtc_i) begin
            flags_q <= '{tflag: 1'b1, pflag: 1'b1};
            pulse_q <= 1'b1;
         end
      end
   end

   assign asleep_o    = (pwr_q == PWR_SLEEP);
   assign tflag_o     = flags_q.tflag;
   assign pflag_o     = flags_q.pflag;
   assign clr_pulse_o = pulse_q;
endmodule

// File: rtl/rstpd_ctrl.sv
module rstpd_ctrl #(
   parameter int HOLD_TICKS = 8,
   parameter int CTL_W      = 6,
   parameter int STAT_TOP_W = 3,
   parameter int PORT_W     = 12
) (
   input  logic                  clk,
   input  logic                  por_i,
   input  logic                  rst_pin_n_i,
   input  logic                  wdt_expire_i,
   input  logic                  wdt_en_i,
   input  logic                  sleep_i,
   input  logic                  wdtc_i,
   input  logic                  tick_i,
   output logic                  core_rst_o,
   output logic                  osc_stop_o,
   output logic                  tflag_o,
   output logic                  pflag_o,
   output logic                  wdt_clr_o,
   output logic [CTL_W-1:0]      init_tmrctl_o,
   output logic [STAT_TOP_W-1:0] init_stat_top_o,
   output logic [PORT_W-1:0]     init_port_dir_o,
   output logic                  init_wden_o,
   output logic                  init_ropt_o
);
   generate
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("rstpd_ctrl: HOLD_TICKS must be at least 1");
      end
      if (CTL_W < 1 || CTL_W > 8) begin : g_bad_ctl
         $error("rstpd_ctrl: CTL_W must be 1..8");
      end
      if (STAT_TOP_W < 1 || STAT_TOP_W > 8) begin : g_bad_stat
         $error("rstpd_ctrl: STAT_TOP_W must be 1..8");
      end
      if (PORT_W < 1) begin : g_bad_port
         $error("rstpd_ctrl: PORT_W must be at least 1");
      end
   endgenerate

   logic ev;
   logic wdt_ev;
   logic hold;
   logic clr_pulse;

   rstpd_event u_event (
      .rst_pin_n_i  (rst_pin_n_i),
      .wdt_expire_i (wdt_expire_i),
      .wdt_en_i     (wdt_en_i),
      .ev_o         (ev),
      .wdt_ev_o     (wdt_ev)
   );

   rstpd_hold #(
      .HOLD_TICKS (HOLD_TICKS)
   ) u_hold (
      .clk    (clk),
      .por_i  (por_i),
      .ev_i   (ev),
      .tick_i (tick_i),
      .hold_o (hold)
   );

   rstpd_power u_power (
      .clk         (clk),
      .por_i       (por_i),
      .ev_i        (ev),
      .wdt_ev_i    (wdt_ev),
      .hold_i      (hold),
      .sleep_i     (sleep_i),
      .wdtc_i      (wdtc_i),
      .asleep_o    (osc_stop_o),
      .tflag_o     (tflag_o),
      .pflag_o     (pflag_o),
      .clr_pulse_o (clr_pulse)
   );

   assign core_rst_o      = hold;
   assign wdt_clr_o       = hold | clr_pulse;
   assign init_tmrctl_o   = '1;
   assign init_stat_top_o = '0;
   assign init_port_dir_o = '1;
   assign init_wden_o     = 1'b1;
   assign init_ropt_o     = 1'b0;
endmodule

module rstpd_ctrl_chk (
   input logic clk,
   input logic por_i,
   input logic rst_pin_n_i,
   input logic wdt_expire_i,
   input logic wdt_en_i,
   input logic sleep_i,
   input logic wdtc_i,
   input logic tick_i,
   input logic core_rst_o,
   input logic osc_stop_o,
   input logic tflag_o,
   input logic pflag_o,
   input logic wdt_clr_o
);
   logic ev_c;
   logic acc_c;

   assign ev_c  = ~rst_pin_n_i | (wdt_expire_i & wdt_en_i);
   assign acc_c = ~ev_c & ~core_rst_o & ~osc_stop_o;

   // R3
   release_on_tick_chk: assert property (@(posedge clk) disable iff (por_i)
      $fell(core_rst_o) |-> ($past(tick_i) && $past(rst_pin_n_i)));

   // R4
   event_holds_chk: assert property (@(posedge clk) disable iff (por_i)
      ev_c |=> core_rst_o);

   // R5
   sleep_entry_chk: assert property (@(posedge clk) disable iff (por_i)
      (acc_c && sleep_i) |=> (osc_stop_o && tflag_o && !pflag_o));

   // R6
   wdtc_flags_chk: assert property (@(posedge clk) disable iff (por_i)
      (acc_c && wdtc_i && !sleep_i) |=> (tflag_o && pflag_o));

   // R7
   timeout_clears_t_chk: assert property (@(posedge clk) disable iff (por_i)
      (wdt_expire_i && wdt_en_i) |=> (!tflag_o && $stable(pflag_o)));

   // R8
   sleep_sticky_chk: assert property (@(posedge clk) disable iff (por_i)
      (osc_stop_o && !ev_c) |=> osc_stop_o);

   // R9
   clr_in_reset_chk: assert property (@(posedge clk) disable iff (por_i)
      core_rst_o |-> wdt_clr_o);
endmodule

bind rstpd_ctrl rstpd_ctrl_chk u_chk (
   .clk          (clk),
   .por_i        (por_i),
   .rst_pin_n_i  (rst_pin_n_i),
   .wdt_expire_i (wdt_expire_i),
   .wdt_en_i     (wdt_en_i),
   .sleep_i      (sleep_i),
   .wdtc_i       (wdtc_i),
   .tick_i       (tick_i),
   .core_rst_o   (core_rst_o),
   .osc_stop_o   (osc_stop_o),
   .tflag_o      (tflag_o),
   .pflag_o      (pflag_o),
   .wdt_clr_o    (wdt_clr_o)
);

// File: tb/rstpd_ctrl_tb.sv
`timescale 1ns/1ps
module rstpd_ctrl_tb;
   localparam int H  = 3;
   localparam int CW = 6;
   localparam int SW = 3;
   localparam int PW = 12;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por, pin_n, wto, wen, slp, wdc, tk;
   logic core_rst, osc_stop, tflag, pflag, wdt_clr;
   logic [CW-1:0] i_tmr;
   logic [SW-1:0] i_stat;
   logic [PW-1:0] i_dir;
   logic i_wden, i_ropt;

   rstpd_ctrl #(.HOLD_TICKS(H), .CTL_W(CW), .STAT_TOP_W(SW), .PORT_W(PW)) u_dut (
      .clk(clk), .por_i(por), .rst_pin_n_i(pin_n), .wdt_expire_i(wto),
      .wdt_en_i(wen), .sleep_i(slp), .wdtc_i(wdc), .tick_i(tk),
      .core_rst_o(core_rst), .osc_stop_o(osc_stop), .tflag_o(tflag),
      .pflag_o(pflag), .wdt_clr_o(wdt_clr), .init_tmrctl_o(i_tmr),
      .init_stat_top_o(i_stat), .init_port_dir_o(i_dir),
      .init_wden_o(i_wden), .init_ropt_o(i_ropt)
   );

   typedef struct {
      string      tag;
      logic [4:0] exp;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference state
   bit m_hold, m_sleep, m_t, m_p;
   int m_cnt;

   function automatic logic [4:0] outs();
      return {core_rst, osc_stop, tflag, pflag, wdt_clr};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_por();
      m_hold = 1; m_cnt = 0; m_sleep = 0; m_t = 1; m_p = 1;
   endtask

   // driver: apply one cycle of stimulus and push the expected outputs
   task automatic cyc(string tag, bit p_n, bit w_to, bit w_en, bit s, bit c, bit t);
      bit ev, acc, pulse;
      item_t it;
      @(negedge clk);
      pin_n = p_n; wto = w_to; wen = w_en; slp = s; wdc = c; tk = t;
      ev    = !p_n || (w_to && w_en);
      acc   = !ev && !m_hold && !m_sleep;
      pulse = 0;
      if (ev) begin
         m_hold = 1; m_cnt = 0; m_sleep = 0;
         if (w_to && w_en) m_t = 0;
      end else if (m_hold && t) begin
         if (m_cnt == H - 1) begin m_hold = 0; m_cnt = 0; end
         else m_cnt++;
      end
      if (acc && s) begin
         m_sleep = 1; m_t = 1; m_p = 0; pulse = 1;
      end else if (acc && c) begin
         m_t = 1; m_p = 1; pulse = 1;
      end
      it.tag = tag;
      it.exp = {m_hold, m_sleep, m_t, m_p, m_hold | pulse};
      q.push_back(it);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) cyc(tag, 1, 0, 1, 0, 0, 0);
   endtask

   task automatic ticks(string tag, int n);
      for (int i = 0; i < n; i++) cyc(tag, 1, 0, 1, 0, 0, 1);
   endtask

   // monitor: compare queued expectations after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, 32'(outs()), 32'(it.exp));
         end
      end
   end

   // watchdog
   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      por = 1; pin_n = 1; wto = 0; wen = 1; slp = 0; wdc = 0; tk = 0;
      model_por();
      #1;
      check("R1 power-on outputs", 32'(outs()), 32'(5'b10111));
      check("R10 timer ctl default", 32'(i_tmr), 32'({CW{1'b1}}));
      check("R10 status top default", 32'(i_stat), 32'd0);
      check("R10 port dir default", 32'(i_dir), 32'({PW{1'b1}}));
      check("R10 wden/ropt default", 32'({i_wden, i_ropt}), 32'(2'b10));
      repeat (2) @(negedge clk);
      por = 0;
      model_por();

      idle("R3 hold without ticks", 4);
      ticks("R3 count to release", 3);
      idle("R3 released", 2);

      cyc("R6 wdtc strobe", 1, 0, 1, 0, 1, 0);
      idle("R9 clear pulse ends", 1);
      cyc("R2 disabled expiry ignored", 1, 1, 0, 0, 0, 0);
      idle("R2 no effect", 1);

      cyc("R5 sleep strobe", 1, 0, 1, 1, 0, 0);
      cyc("R8 wdtc ignored asleep", 1, 0, 1, 0, 1, 0);
      cyc("R8 sleep persists with tick", 1, 0, 1, 0, 0, 1);
      cyc("R8 pin wakes", 0, 0, 1, 0, 0, 1);
      cyc("R7 pin leaves flags", 0, 0, 1, 0, 0, 0);
      ticks("R4 partial count", 2);
      cyc("R4 restart in hold", 0, 0, 1, 0, 0, 1);
      ticks("R4 needs full count", 2);
      cyc("R8 sleep ignored in hold", 1, 0, 1, 1, 0, 0);
      ticks("R3 final tick", 1);
      idle("R3 after restart", 1);

      cyc("R6 wdtc sets both", 1, 0, 1, 0, 1, 0);
      cyc("R7 awake expiry", 1, 1, 1, 0, 0, 0);
      cyc("R8 strobe during event", 1, 1, 1, 1, 0, 0);
      ticks("R7 release", 3);
      idle("R7 flags kept", 1);

      cyc("R5 sleep again", 1, 0, 1, 1, 0, 0);
      idle("R8 asleep", 2);
      cyc("R7 expiry wakes sleep", 1, 1, 1, 0, 0, 0);
      ticks("R3 release", 3);

      cyc("R11 sleep beats wdtc", 1, 0, 1, 1, 1, 0);
      idle("R11 asleep", 1);
      cyc("R8 pin exit", 0, 0, 1, 0, 0, 0);
      ticks("R3 release", 3);
      idle("R9 idle", 1);

      @(posedge clk);
      #2;
      #1.5;
      por = 1;
      #0.5;
      check("R1 async power-on", 32'(outs()), 32'(5'b10111));
      @(negedge clk);
      por = 0;
      model_por();
      idle("R3 hold after power-on", 2);
      ticks("R3 release after power-on", 3);
      idle("R3 final", 1);

      @(posedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule